// File: doc/BRIEF.md
# PMP Entry Configuration Register

This block is the machine-mode control register that stores the configuration bytes of the physical-memory-protection entries. Each entry has one byte with a lock flag, an address-matching mode and three access permissions (read, write, execute). Depending on a width parameter, the register holds four bytes (32-bit view) or eight bytes (64-bit view). A CSR access port carries the address, the privilege level of the requester, a write enable and write data. Read data is returned in the same cycle.

Each byte of a write is legalized separately. A byte whose stored lock flag is set never changes. A new byte that grants write without read is refused. When the granularity parameter is 2 or more, the four-byte naturally aligned mode is also refused. A refused byte keeps its previous contents and is not coerced. An accepted byte is stored with its two reserved bits cleared. Entries whose index is at or above the configured entry count are absent: they read as zero and ignore writes.

Top module: `pmp_cfg_reg`

## Requirements
- R1: The register responds only when `csr_addr` equals 0x3A0 and `priv` equals 2'b11 (machine mode). In any other case `csr_rdata` is zero and a write changes no byte.
- R2: Entry i occupies bits [8i+7:8i]. With MXL=0 the port is 32 bits wide and holds entries 0–3. With MXL=1 it is 64 bits wide and holds entries 0–7.
- R3: After reset every implemented byte reads 0x00, which means unlocked with mode OFF.
- R4: Bit 7 of a byte is the lock flag. While the stored lock flag is 1, writes leave that byte unchanged.
- R5: Bit 0 is read permission and bit 1 is write permission. A new byte with bit0=0 and bit1=1 is refused, and the stored byte is kept.
- R6: Bits 4:3 are the address mode (0 OFF, 1 TOR, 2 NA4, 3 NAPOT). With GRAN≥2, a new byte with mode 2 is refused. With GRAN<2, mode 2 is accepted.
- R7: Bits 6:5 are reserved. They always read as zero, and the values written to them are ignored.
- R8: Bytes with index ≥ NUM_ENTRIES read as zero and ignore writes.
- R9: Each byte is accepted or refused on its own terms. A refused byte does not block the other bytes of the same write. An accepted byte is stored as written in bits 7 and 4:0.
- R10: A write takes effect at the clock edge on which `csr_we` is sampled high. Reads are combinational from the stored bytes, so the new value is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Privilege level of the requester (2'b11 = machine) |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | 32<<MXL | Write data |
| csr_rdata | output | 32<<MXL | Read data |

## Verification
The bench builds two instances that share the same stimulus. The first uses MXL=1, NUM_ENTRIES=6 and GRAN=2. It exposes the 64-bit layout, two absent upper bytes and the refusal of mode NA4. The second uses MXL=0, NUM_ENTRIES=3 and GRAN=0. It covers the 32-bit view, one absent byte inside the narrow word, and the acceptance of NA4 for the same write data. Random writes with a rarely set lock flag, mixed with off-address and non-machine accesses, reach combinations where refused and accepted bytes share one write.

// File: rtl/pmp_cfg_reg.sv
module pmp_cfg_reg #(
  parameter int          MXL         = 1,
  parameter int          NUM_ENTRIES = 8,
  parameter int          GRAN        = 0,
  parameter logic [11:0] CSR_ADDR    = 12'h3A0,
  localparam int         W           = 32 << MXL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   priv,
  input  logic [11:0]  csr_addr,
  input  logic         csr_we,
  input  logic [W-1:0] csr_wdata,
  output logic [W-1:0] csr_rdata
);
  localparam int SLOTS = W / 8;
  localparam int LIVE  = (NUM_ENTRIES < SLOTS) ? NUM_ENTRIES : SLOTS;

  logic         hit, wr;
  logic [W-1:0] cfg_q;
  logic         unused_wdata;

  assign hit = (csr_addr == CSR_ADDR) && (priv == 2'b11);
  assign wr  = hit && csr_we;
  assign unused_wdata = ^csr_wdata;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < LIVE) begin : g_live
      logic [7:0] q, nb;
      logic       ok;
      assign nb = csr_wdata[8*i +: 8];
      assign ok = !q[7] && !(nb[1] && !nb[0]) &&
                  !((GRAN >= 2) && (nb[4:3] == 2'b10));
      always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (wr && ok) q <= nb & 8'h9F;
      end
      assign cfg_q[8*i +: 8] = q;
    end else begin : g_dead
      assign cfg_q[8*i +: 8] = '0;
    end
  end

  assign csr_rdata = hit ? cfg_q : '0;
endmodule

module pmp_cfg_chk #(
  parameter int MXL         = 1,
  parameter int NUM_ENTRIES = 8,
  parameter int GRAN        = 0,
  localparam int W          = 32 << MXL
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   priv,
  input logic [11:0]  csr_addr,
  input logic         csr_we,
  input logic [W-1:0] cfg_q
);
  localparam int SLOTS = W / 8;

  AST_FOREIGN_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !(csr_addr == 12'h3A0 && priv == 2'b11)) |=> $stable(cfg_q)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> $stable(cfg_q)); // R10

  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    if (i < NUM_ENTRIES) begin : g_live
      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[8*i+7] |=> cfg_q[8*i +: 8] == $past(cfg_q[8*i +: 8])); // R4
      AST_NO_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q[8*i+1] && !cfg_q[8*i])); // R5
      AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[8*i+5 +: 2] == 2'b00); // R7
      if (GRAN >= 2) begin : g_gran
        AST_NO_NA4: assert property (@(posedge clk) disable iff (!rst_n)
          cfg_q[8*i+3 +: 2] != 2'b10); // R6
      end
    end else begin : g_dead
      AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[8*i +: 8] == 8'h00); // R8
    end
  end
endmodule

bind pmp_cfg_reg pmp_cfg_chk #(.MXL(MXL), .NUM_ENTRIES(NUM_ENTRIES), .GRAN(GRAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .csr_addr(csr_addr),
  .csr_we(csr_we), .cfg_q(cfg_q)
);

// File: tb/pmp_cfg_reg_bench.sv
module pmp_cfg_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = 2'b11;
  logic [11:0] csr_addr = 12'h3A0;
  logic        csr_we = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rd_w;
  logic [31:0] rd_n;
  int checks = 0, errors = 0;
  logic [7:0] mw [8];
  logic [7:0] mn [4];

  always #10 clk = ~clk;

  pmp_cfg_reg #(.MXL(1), .NUM_ENTRIES(6), .GRAN(2)) u_pmp_cfg_reg (
    .clk(clk), .rst_n(rst_n), .priv(priv), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(wdata), .csr_rdata(rd_w));
  pmp_cfg_reg #(.MXL(0), .NUM_ENTRIES(3), .GRAN(0)) u_narrow (
    .clk(clk), .rst_n(rst_n), .priv(priv), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(wdata[31:0]), .csr_rdata(rd_n));

  function automatic logic [7:0] legal(logic [7:0] old, logic [7:0] nb, int gran);
    if (old[7]) return old;
    if (nb[1] && !nb[0]) return old;
    if (gran >= 2 && nb[4:3] == 2'b10) return old;
    return nb & 8'h9F;
  endfunction

  function automatic logic [63:0] exp_w();
    logic [63:0] v = '0;
    for (int i = 0; i < 6; i++) v[8*i +: 8] = mw[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_n();
    logic [31:0] v = '0;
    for (int i = 0; i < 3; i++) v[8*i +: 8] = mn[i];
    return v;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) mw[i] = 8'h00;
    for (int i = 0; i < 4; i++) mn[i] = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; csr_we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    model_clear();
  endtask

  task automatic write(logic [11:0] a, logic [1:0] p, logic [63:0] d);
    @(negedge clk);
    csr_addr = a; priv = p; wdata = d; csr_we = 1'b1;
    if (a == 12'h3A0 && p == 2'b11) begin
      for (int i = 0; i < 6; i++) mw[i] = legal(mw[i], d[8*i +: 8], 2);
      for (int i = 0; i < 3; i++) mn[i] = legal(mn[i], d[8*i +: 8], 0);
    end
    @(negedge clk);
    csr_we = 1'b0; csr_addr = 12'h3A0; priv = 2'b11;
  endtask

  task automatic check(string req);
    #1;
    checks++;
    if (rd_w !== exp_w()) begin
      errors++;
      $display("FAIL %s wide: got %h exp %h", req, rd_w, exp_w());
    end
    checks++;
    if (rd_n !== exp_n()) begin
      errors++;
      $display("FAIL %s narrow: got %h exp %h", req, rd_n, exp_n());
    end
  endtask

  task automatic check_zero(string req);
    #1;
    checks++;
    if (rd_w !== 64'h0 || rd_n !== 32'h0) begin
      errors++;
      $display("FAIL %s: got %h/%h exp 0/0", req, rd_w, rd_n);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    model_clear();
    do_reset();
    check("R3 reset");

    write(12'h3A0, 2'b11, 64'h0D0B_0F0B_0903_0501); check("R2 R10 legal bytes");
    write(12'h3A0, 2'b11, 64'h1111_1111_1111_1111); check("R6 NA4 by granularity");
    write(12'h3A0, 2'b11, 64'h0303_0302_0203_0201); check("R5 R9 write-only refused per byte");
    write(12'h3A0, 2'b11, 64'hFFFF_FF7B_7B7B_7B7B);
    check("R7 R8 reserved bits and absent bytes");
    write(12'h3A1, 2'b11, 64'h0101_0101_0101_0101); check("R1 other address");
    priv = 2'b01; check_zero("R1 non-machine read");
    write(12'h3A0, 2'b01, 64'h0101_0101_0101_0101); check("R1 non-machine write");
    write(12'h3A0, 2'b11, 64'h0000_0000_0089_0000); check("R4 set lock");
    write(12'h3A0, 2'b11, 64'h0000_0000_0000_0000); check("R4 locked byte kept");
    write(12'h3A0, 2'b11, 64'h0000_0000_0018_0707); check("R4 R9 others still writable");

    do_reset();
    check("R3 second reset");
    for (int n = 0; n < 400; n++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [11:0] a = ($urandom % 8 == 0) ? 12'h3A2 : 12'h3A0;
      logic [1:0]  p = ($urandom % 8 == 0) ? 2'b01 : 2'b11;
      if ($urandom % 16 != 0) d = d & 64'h7F7F_7F7F_7F7F_7F7F;
      write(a, p, d);
      check("R9 random write");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule